// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host port and an external asynchronous static RAM of 64K words by 16 bits. The RAM has active-low strobes for chip select, write enable and output enable, plus one active-low enable per byte lane. A host request carries an address, write data, a per-lane mask and a read/write flag. The controller turns each request into a complete strobe sequence. For reads it returns the captured word with a one-cycle valid pulse.

All waits come from nanosecond limits and a clock-period parameter. Each count is rounded up to whole cycles, and a count never falls below one. Two rules protect the shared data pins. The controller never drives a lane while the memory's output enable is active. After output enable rises, it holds back its own drive for the memory's release time. A request with an empty lane mask is taken and dropped.

Top module: `bsram_ctrl`

## Requirements
- R1: During and after reset, all memory strobes and lane enables are high, no lane is driven, rsp_valid is low, and req_ready is high. A reset asserted in the middle of a write releases the strobes and the drive at once.
- R2: When a read with a non-empty mask is accepted, the next cycle shows the request address, chip select low, output enable low and write enable high. The mask is applied as lane enables: mask bit 0 drives lane enable bit 0 (data bits 7:0) and mask bit 1 drives lane enable bit 1 (data bits 15:8). Output enable stays low for exactly ceil(85 ns / period) cycles, 11 at 8 ns, with the address held.
- R3: The read word is captured on the edge that ends the access. In that same edge rsp_valid is raised for one cycle and the strobes are released. The result shows memory data on enabled lanes and zero on disabled lanes.
- R4: An accepted write drives chip select and write enable low and keeps output enable high, with lanes from the mask as in R2. Write enable stays low for max(ceil(70 ns / period), turnaround + ceil(35 ns / period)) cycles, 9 at 8 ns when no turnaround is pending.
- R5: mem_dq_oe is set only on masked lanes, only while write enable is low and output enable is high, and carries the request data. It turns on only once output enable has been high for ceil(30 ns / period) cycles (4 at 8 ns). It stays on for at least ceil(35 ns / period) cycles, and turns off on the edge that raises write enable.
- R6: After any accepted non-empty request, req_ready stays low for at least ceil(85 ns / period) - 1 cycles. It returns high in the first cycle that is both idle and past the full cycle time: cycle 11 after a write and cycle 12 after a read at 8 ns.
- R7: A request whose mask is all zero is accepted and has no effect. No strobe falls, no read response is produced, req_ready stays high, and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | 16 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low |
| mem_dq_out | output | 16 | Data to the memory pins |
| mem_dq_oe | output | 2 | Per-lane pin drive enable |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
Two events can land in the same cycle when a write is queued right behind a read. One is the end of the read: the data capture and the release of output enable. The other is the start of the write: write enable falls while the bus is still inside the memory's release window. The bench provokes this by holding a write request ready when the read finishes, with zero, two or more idle cycles in between. It then checks the first cycle in which the data lanes are driven against the turnaround count, and checks that the write pulse is stretched only when the data setup would otherwise be too short. It also checks that no cycle has the lane drive and output enable active together.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } bsram_state_e;

   // Whole cycles covering a nanosecond limit, never fewer than one.
   function automatic int ns_to_cycles(int ns, int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bsram_hz_track.sv
module bsram_hz_track #(
   parameter int HZ_CYC = 4,
   parameter int CNT_W  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic hz_ok
);

   logic [CNT_W-1:0] hi_cnt;

   // Counts completed cycles with output enable high, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= CNT_W'(HZ_CYC);
      end else if (!oe_n) begin
         hi_cnt <= '0;
      end else if (hi_cnt < CNT_W'(HZ_CYC)) begin
         hi_cnt <= hi_cnt + CNT_W'(1);
      end
   end

   // True when the current cycle completes the release window.
   assign hz_ok = oe_n && (hi_cnt >= CNT_W'(HZ_CYC - 1));

endmodule

// File: rtl/bsram_fsm.sv
module bsram_fsm
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int LANES   = 2,
   parameter int RD_CYC  = 11,
   parameter int CYC_CYC = 11,
   parameter int WP_CYC  = 9,
   parameter int DS_CYC  = 5,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   input  logic              hz_ok,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              cs_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [LANES-1:0]  lane_n,
   output logic              drive,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  mask_q,
   output logic              capture
);

   bsram_state_e     state;
   logic [CNT_W-1:0] op_cnt;
   logic [CNT_W-1:0] ds_cnt;
   logic [CNT_W-1:0] cyc_cnt;
   logic             accept;
   logic             rd_done;
   logic             wr_done;

   assign req_ready = (state == ST_IDLE) && (cyc_cnt == '0);
   assign accept    = req_valid && req_ready;
   assign rd_done   = (state == ST_READ) &&
                      ((op_cnt + CNT_W'(1)) >= CNT_W'(RD_CYC));
   assign wr_done   = (state == ST_WRITE) && drive &&
                      ((op_cnt + CNT_W'(1)) >= CNT_W'(WP_CYC)) &&
                      ((ds_cnt + CNT_W'(1)) >= CNT_W'(DS_CYC));
   assign capture   = rd_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_cnt   <= '0;
         ds_cnt   <= '0;
         cyc_cnt  <= '0;
         mem_addr <= '0;
         wdata_q  <= '0;
         mask_q   <= '0;
         cs_n     <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         lane_n   <= '1;
         drive    <= 1'b0;
      end else begin
         if (cyc_cnt != '0) cyc_cnt <= cyc_cnt - CNT_W'(1);
         unique case (state)
            ST_IDLE: begin
               if (accept && (|req_mask)) begin
                  mem_addr <= req_addr;
                  wdata_q  <= req_wdata;
                  mask_q   <= req_mask;
                  cs_n     <= 1'b0;
                  lane_n   <= ~req_mask;
                  op_cnt   <= '0;
                  ds_cnt   <= '0;
                  cyc_cnt  <= CNT_W'(CYC_CYC - 1);
                  if (req_write) begin
                     we_n  <= 1'b0;
                     drive <= hz_ok;
                     state <= ST_WRITE;
                  end else begin
                     oe_n  <= 1'b0;
                     state <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               op_cnt <= op_cnt + CNT_W'(1);
               if (rd_done) begin
                  cs_n   <= 1'b1;
                  oe_n   <= 1'b1;
                  lane_n <= '1;
                  state  <= ST_IDLE;
               end
            end
            ST_WRITE: begin
               op_cnt <= op_cnt + CNT_W'(1);
               if (drive) ds_cnt <= ds_cnt + CNT_W'(1);
               if (!drive && hz_ok) drive <= 1'b1;
               if (wr_done) begin
                  cs_n   <= 1'b1;
                  we_n   <= 1'b1;
                  lane_n <= '1;
                  drive  <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: a write strobe never overlaps output enable and needs chip select
   a_r4_write_excludes_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (oe_n && !cs_n));

   // R2: address held while read strobes are active
   a_r2_read_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && !cs_n) |=> (oe_n || $stable(mem_addr)));

   // R6: no new request while an access is on the pins
   a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !req_ready);

   // R7: an empty mask leaves chip select high
   a_r7_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_mask == '0) && cs_n) |=> cs_n);

endmodule

// File: rtl/bsram_lane_io.sv
module bsram_lane_io #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    drive,
   input  logic                    capture,
   input  logic [LANES-1:0]        mask_q,
   input  logic [LANES*LANE_W-1:0] wdata_q,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic [LANES-1:0]        dq_oe,
   output logic                    rsp_valid,
   output logic [LANES*LANE_W-1:0] rsp_rdata
);

   assign dq_out = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= capture;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dq_oe[l] = drive && mask_q[l];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_rdata[l*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rsp_rdata[l*LANE_W +: LANE_W] <=
               mask_q[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
         end
      end
   end

   // R3: the read result strobe lasts a single cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int LANE_W  = 8,
   parameter int CLK_NS  = 8,
   parameter int T_RC_NS = 85,
   parameter int T_AA_NS = 85,
   parameter int T_WC_NS = 85,
   parameter int T_WP_NS = 55,
   parameter int T_CW_NS = 70,
   parameter int T_DW_NS = 35,
   parameter int T_HZ_NS = 30,
   localparam int LANES  = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [LANES-1:0]  mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int RD_CYC  = ns_to_cycles(T_AA_NS, CLK_NS);
   localparam int CYC_CYC = ns_to_cycles(max2(T_RC_NS, T_WC_NS), CLK_NS);
   localparam int WP_CYC  = ns_to_cycles(max2(T_WP_NS, T_CW_NS), CLK_NS);
   localparam int DS_CYC  = ns_to_cycles(T_DW_NS, CLK_NS);
   localparam int HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_NS);
   localparam int CNT_W   = $clog2(CYC_CYC + RD_CYC + WP_CYC + DS_CYC + HZ_CYC + 2);

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be positive");
   end

   logic              hz_ok;
   logic              drive;
   logic              capture;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;

   bsram_hz_track #(
      .HZ_CYC (HZ_CYC),
      .CNT_W  (CNT_W)
   ) u_hz (
      .clk   (clk),
      .rst_n (rst_n),
      .oe_n  (mem_oe_n),
      .hz_ok (hz_ok)
   );

   bsram_fsm #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .LANES   (LANES),
      .RD_CYC  (RD_CYC),
      .CYC_CYC (CYC_CYC),
      .WP_CYC  (WP_CYC),
      .DS_CYC  (DS_CYC),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .hz_ok     (hz_ok),
      .mem_addr  (mem_addr),
      .cs_n      (mem_cs_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .lane_n    (mem_lane_n),
      .drive     (drive),
      .wdata_q   (wdata_q),
      .mask_q    (mask_q),
      .capture   (capture)
   );

   bsram_lane_io #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_io (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive     (drive),
      .capture   (capture),
      .mask_q    (mask_q),
      .wdata_q   (wdata_q),
      .dq_in     (mem_dq_in),
      .dq_out    (mem_dq_out),
      .dq_oe     (mem_dq_oe),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   // Independent count of cycles with output enable high, for the checks.
   logic [CNT_W-1:0] chk_oe_hi;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             chk_oe_hi <= CNT_W'(HZ_CYC);
      else if (!mem_oe_n)                     chk_oe_hi <= '0;
      else if (chk_oe_hi < CNT_W'(HZ_CYC))    chk_oe_hi <= chk_oe_hi + CNT_W'(1);
   end

   // R5: pins driven only inside a write strobe, never with output enable
   a_r5_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|mem_dq_oe) |-> (!mem_we_n && mem_oe_n));

   // R5: drive waits for the memory's release time
   a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      (|mem_dq_oe) |-> (chk_oe_hi >= CNT_W'(HZ_CYC)));

   // R5: a driven lane is an enabled lane
   a_r5_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe & mem_lane_n) == '0);

   // R2: read strobes carry at least one enabled lane
   a_r2_read_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_cs_n && mem_we_n && (mem_lane_n != '1)));

endmodule

// File: tb/bsram_ctrl_bench.sv
module bsram_ctrl_bench;

   localparam int CLK  = 8;
   localparam int RD   = (85 + CLK - 1) / CLK;
   localparam int CYC  = (85 + CLK - 1) / CLK;
   localparam int WP   = (70 + CLK - 1) / CLK;
   localparam int DS   = (35 + CLK - 1) / CLK;
   localparam int HZ   = (30 + CLK - 1) / CLK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [15:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n;
   logic [1:0]  mem_lane_n;
   logic [15:0] mem_dq_out;
   logic [1:0]  mem_dq_oe;
   logic [15:0] mem_dq_in;

   int checks = 0;
   int errors = 0;

   always #(CLK/2) clk = ~clk;

   bsram_ctrl u_bsram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Small memory model keyed by the low address nibble.
   logic [15:0] model  [16];
   logic [15:0] shadow [16];

   always @(negedge clk) begin
      if (!mem_we_n && !mem_cs_n) begin
         for (int l = 0; l < 2; l++)
            if (!mem_lane_n[l] && mem_dq_oe[l])
               model[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      end
   end

   always_comb begin
      mem_dq_in = 16'hDEAD;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         for (int l = 0; l < 2; l++)
            mem_dq_in[l*8 +: 8] = mem_lane_n[l] ? 8'hEE : model[mem_addr[3:0]][l*8 +: 8];
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] wdata;
      logic [1:0]  mask;
      logic [3:0]  gap;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{1'b1, 16'h0003, 16'hA1B2, 2'b11, 4'd0},
      '{1'b0, 16'h0003, 16'h0000, 2'b11, 4'd0},
      '{1'b1, 16'h0003, 16'h5566, 2'b01, 4'd0},
      '{1'b0, 16'h0003, 16'h0000, 2'b11, 4'd0},
      '{1'b0, 16'h0003, 16'h0000, 2'b10, 4'd0},
      '{1'b1, 16'h0003, 16'h7788, 2'b10, 4'd2},
      '{1'b0, 16'h0003, 16'h0000, 2'b01, 4'd0},
      '{1'b1, 16'hFFF5, 16'h1234, 2'b00, 4'd0},
      '{1'b0, 16'hFFF5, 16'h0000, 2'b11, 4'd0},
      '{1'b1, 16'h1000, 16'hBEEF, 2'b11, 4'd6},
      '{1'b0, 16'h1000, 16'h0000, 2'b11, 4'd0},
      '{1'b0, 16'h0003, 16'h0000, 2'b11, 4'd3}
   };

   bit last_read = 1'b0;

   task automatic run_op(input vec_t v);
      int k, we_cnt, oe_cnt, first, drv, rsp_k, ready_k;
      bit data_bad, lane_bad, clash, early;
      logic [15:0] rsp_d, exp_d;
      int exp_first, exp_we;
      for (int g = 0; g < int'(v.gap); g++) begin
         req_valid = 1'b0;
         @(negedge clk);
      end
      req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata; req_mask = v.mask;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      we_cnt = 0; oe_cnt = 0; first = 0; drv = 0; rsp_k = 0; ready_k = 0;
      data_bad = 0; lane_bad = 0; clash = 0; early = 0; rsp_d = '0;
      if (v.mask != 2'b00)
         check(mem_addr == v.addr, v.wr ? "R4" : "R2", "address", mem_addr, v.addr);
      for (k = 1; k < 30; k++) begin
         if (!mem_we_n) we_cnt++;
         if (!mem_oe_n) oe_cnt++;
         if (mem_dq_oe != 2'b00) begin
            if (first == 0) first = k;
            drv++;
            if (mem_dq_oe != v.mask || mem_dq_out != v.wdata) data_bad = 1;
         end
         if (!mem_cs_n && mem_lane_n != ~v.mask) lane_bad = 1;
         if (!mem_oe_n && mem_dq_oe != 2'b00) clash = 1;
         if (rsp_valid) begin rsp_k = k; rsp_d = rsp_rdata; end
         if (req_ready) begin
            if (v.mask != 2'b00 && k < CYC) early = 1;
            ready_k = k;
            break;
         end
         @(negedge clk);
      end
      if (v.mask == 2'b00) begin
         check(mem_cs_n && we_cnt == 0 && oe_cnt == 0, "R7", "strobes on empty mask", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
         check(ready_k == 1 && rsp_k == 0, "R7", "ready/rsp on empty mask", ready_k, 1);
         return;
      end
      check(!lane_bad, v.wr ? "R4" : "R2", "lane enables", mem_lane_n, ~v.mask);
      check(!clash, "R5", "drive during output enable", 1, 0);
      check(!early, "R6", "ready early", ready_k, CYC);
      if (v.wr) begin
         exp_first = last_read ? ((HZ - int'(v.gap)) > 1 ? HZ - int'(v.gap) : 1) : 1;
         exp_we = (WP > exp_first - 1 + DS) ? WP : exp_first - 1 + DS;
         check(we_cnt == exp_we, "R4", "write pulse cycles", we_cnt, exp_we);
         check(oe_cnt == 0, "R4", "output enable during write", oe_cnt, 0);
         check(first == exp_first, "R5", "first driven cycle", first, exp_first);
         check(drv == exp_we - exp_first + 1, "R5", "driven cycles", drv, exp_we - exp_first + 1);
         check(!data_bad, "R5", "driven data/lanes", mem_dq_out, v.wdata);
         check(rsp_k == 0, "R3", "no response on write", rsp_k, 0);
         check(ready_k == ((CYC > exp_we + 1) ? CYC : exp_we + 1), "R6", "ready return", ready_k, CYC);
         for (int l = 0; l < 2; l++)
            if (v.mask[l]) shadow[v.addr[3:0]][l*8 +: 8] = v.wdata[l*8 +: 8];
         last_read = 1'b0;
      end else begin
         exp_d = shadow[v.addr[3:0]] & {{8{v.mask[1]}}, {8{v.mask[0]}}};
         check(oe_cnt == RD && we_cnt == 0, "R2", "read strobe cycles", oe_cnt, RD);
         check(rsp_k == RD + 1, "R3", "response cycle", rsp_k, RD + 1);
         check(rsp_d == exp_d, "R3", "read data", rsp_d, exp_d);
         check(ready_k == RD + 1, "R6", "ready return", ready_k, RD + 1);
         check(drv == 0, "R5", "no drive on read", drv, 0);
         last_read = 1'b1;
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         model[i]  = 16'hC0DE ^ (16'(i) * 16'h0101);
         shadow[i] = 16'hC0DE ^ (16'(i) * 16'h0101);
      end
      repeat (3) @(negedge clk);
      // R1: state held in reset
      check(mem_cs_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11, "R1", "strobes in reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n}, 5'h1F);
      check(mem_dq_oe == 2'b00 && !rsp_valid, "R1", "drive/rsp in reset", mem_dq_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R1", "ready after reset", req_ready, 1);

      for (int i = 0; i < 12; i++) run_op(VECS[i]);

      // R1: reset in the middle of a write
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      req_write = 1'b1; req_addr = 16'h0007; req_wdata = 16'h0F0F; req_mask = 2'b11;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(!mem_we_n && mem_dq_oe == 2'b11, "R4", "write running before reset", mem_dq_oe, 3);
      rst_n = 1'b0;
      #1;
      check(mem_we_n && mem_cs_n && mem_dq_oe == 2'b00 && mem_lane_n == 2'b11, "R1",
            "mid-write reset release", {mem_we_n, mem_cs_n, mem_dq_oe}, 4'hC);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid, "R1", "ready after mid-write reset", req_ready, 1);

      finish_run();
   end

endmodule